// File: doc/BRIEF.md
# MAC Event Statistics Counter Bank

This block keeps a small set of event counters for a wireless MAC. Four counters record successful RTS exchanges, failed RTS exchanges, missing ACKs and frames with a bad FCS. Each counter advances by one on a single-cycle pulse from its event source. Software reads a counter through a plain read port, and every read clears the counter that was read. Software can therefore collect deltas without keeping its own history.

A four-bit control word acts on all counters at once. It can freeze counting, zero every counter, or push every counter up by one for test. It also holds the enable for a shared warning interrupt. Counters stop at a fixed threshold below their full range (0xC000 by default) instead of wrapping. While the warning is enabled, any counter at that threshold raises the interrupt, so software can empty the bank before data is lost.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter reads 0, the interrupt is low, and both stored control bits (warning enable and freeze) are 0.
- R2: An event pulse on evt_i[i] adds one to counter i. Index 0 is RTS success, 1 is RTS failure, 2 is ACK failure and 3 is FCS failure. Pulses on several indices in one cycle each count.
- R3: A read with rd_en_i and rd_addr_i = i shows counter i's value on rd_data_o in the cycle after the read edge. Counter i is zero from that edge on.
- R4: When a read of counter i and a counting event on counter i share a cycle, the read returns the value before the event and the counter ends at 1.
- R5: Control bit 1 (freeze) stops event pulses from counting, starting the cycle after it is written. Reads still return and clear the counters while frozen.
- R6: Control bit 2 (clear) zeroes every counter at the write edge. It is not stored, and it takes priority over events, strobe and reads.
- R7: Control bit 3 (strobe) adds one to every counter at the write edge, even while frozen. A strobe together with an event on the same counter adds one, not two.
- R8: A counter that reaches the threshold THRESH (default 0xC000) holds that value until it is read or cleared, and never exceeds it.
- R9: irq_o is high exactly when control bit 0 (warning enable) is set and at least one counter equals THRESH. It drops once every counter is below THRESH or the enable is cleared.
- R10: Each control write replaces both stored bits (warning enable and freeze) with the written values. Clear and strobe have no lasting effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_CNT | One-cycle event pulses, one per counter |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_data_i | input | 4 | Control word: bit0 warn enable, bit1 freeze, bit2 clear, bit3 strobe |
| rd_en_i | input | 1 | Clearing read request |
| rd_addr_i | input | AW | Index of the counter to read |
| rd_data_o | output | CNT_W | Value of the last counter read, valid one cycle after the request |
| irq_o | output | 1 | Level warning interrupt |

## Verification
On every cycle, the assertions check several properties of the counters. A counter never passes the threshold. A clear leaves it at zero, and a frozen counter with no strobe, clear or read stays put. A counted event during a read leaves it at 1, and the interrupt is low after a clear. Other behaviours can only be shown by the bench's scenarios. These include the arithmetic of accumulated counts under many event masks, the timing of freeze relative to its write, strobes on frozen counters, and reads that return pre-event values. They also include the interrupt rising and falling as counters saturate, are read, and as the enable toggles.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
   localparam int unsigned CTL_W = 4;

   // control word, bit 3 down to bit 0
   typedef struct packed {
      logic strobe;
      logic clear;
      logic freeze;
      logic warn_en;
   } ctl_cmd_t;
endpackage

// File: rtl/stat_ctl_reg.sv
module stat_ctl_reg
   import stat_bank_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output logic             warn_en_o,
   output logic             freeze_o,
   output logic             clear_o,
   output logic             strobe_o
);
   ctl_cmd_t cmd;
   assign cmd = ctl_cmd_t'(wr_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_en_o <= 1'b0;
         freeze_o  <= 1'b0;
      end else if (wr_en) begin
         warn_en_o <= cmd.warn_en;
         freeze_o  <= cmd.freeze;
      end
   end

   // self-clearing actions exist only in the write cycle
   assign clear_o  = wr_en & cmd.clear;
   assign strobe_o = wr_en & cmd.strobe;

   assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(warn_en_o) && $stable(freeze_o)));
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned THRESH = 32'hC000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             event_i,
   input  logic             freeze_i,
   input  logic             strobe_i,
   input  logic             clear_i,
   input  logic             rd_hit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             at_thr_o
);
   localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);

   if ((THRESH >> CNT_W) != 0 || THRESH == 0) begin : g_bad_thresh
      $error("stat_counter: THRESH must be nonzero and fit in CNT_W bits");
   end
   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
      $error("stat_counter: CNT_W out of range");
   end

   logic bump;
   assign bump     = (event_i & ~freeze_i) | strobe_i;
   assign at_thr_o = (cnt_o == THR_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (clear_i) begin
         cnt_o <= '0;
      end else if (rd_hit_i) begin
         cnt_o <= {{(CNT_W-1){1'b0}}, bump};
      end else if (bump && !at_thr_o) begin
         cnt_o <= cnt_o + CNT_W'(1);
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= THR_V);
   assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_o == '0));
   assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_i && !strobe_i && !clear_i && !rd_hit_i) |=> $stable(cnt_o));
   assert_read_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit_i && !clear_i && event_i && !freeze_i) |=> (cnt_o == CNT_W'(1)));
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (event_i && !freeze_i && !clear_i && !rd_hit_i && (cnt_o < THR_V))
      |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/stat_irq.sv
module stat_irq #(
   parameter int unsigned NUM_CNT = 4
) (
   input  logic               warn_en_i,
   input  logic [NUM_CNT-1:0] at_thr_i,
   output logic               irq_o
);
   assign irq_o = warn_en_i & (|at_thr_i);
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
   import stat_bank_pkg::*;
#(
   parameter int unsigned NUM_CNT = 4,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned THRESH  = 32'hC000,
   parameter bit          RD_REG  = 1'b1,
   localparam int unsigned AW     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CNT-1:0] evt_i,
   input  logic               ctl_wr_i,
   input  logic [CTL_W-1:0]   ctl_data_i,
   input  logic               rd_en_i,
   input  logic [AW-1:0]      rd_addr_i,
   output logic [CNT_W-1:0]   rd_data_o,
   output logic               irq_o
);
   if (NUM_CNT < 1 || NUM_CNT > 64) begin : g_bad_count
      $error("mac_stat_bank: NUM_CNT out of range");
   end

   logic warn_en, freeze, clr_p, stb_p;
   logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
   logic [NUM_CNT-1:0] at_thr;
   logic [CNT_W-1:0]   rd_mux;

   stat_ctl_reg u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctl_wr_i),
      .wr_data   (ctl_data_i),
      .warn_en_o (warn_en),
      .freeze_o  (freeze),
      .clear_o   (clr_p),
      .strobe_o  (stb_p)
   );

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      logic rd_hit;
      assign rd_hit = rd_en_i && (rd_addr_i == AW'(g));
      stat_counter #(.CNT_W(CNT_W), .THRESH(THRESH)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .event_i  (evt_i[g]),
         .freeze_i (freeze),
         .strobe_i (stb_p),
         .clear_i  (clr_p),
         .rd_hit_i (rd_hit),
         .cnt_o    (cnt_arr[g]),
         .at_thr_o (at_thr[g])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (rd_addr_i == AW'(i)) rd_mux = cnt_arr[i];
      end
   end

   if (RD_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rd_data_o <= '0;
         else if (rd_en_i) rd_data_o <= rd_mux;
      end
      assert_read_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en_i |=> (rd_data_o == $past(rd_mux)));
   end else begin : g_rd_comb
      assign rd_data_o = rd_mux;
   end

   stat_irq #(.NUM_CNT(NUM_CNT)) u_irq (
      .warn_en_i (warn_en),
      .at_thr_i  (at_thr),
      .irq_o     (irq_o)
   );

   assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_p |=> !irq_o);
endmodule

// File: tb/tb_mac_stat_bank.sv
module tb_mac_stat_bank;
   localparam int N   = 4;
   localparam int W   = 8;
   localparam int THR = 'hC0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt = '0;
   logic         ctl_wr = 1'b0;
   logic [3:0]   ctl_data = '0;
   logic         rd_en = 1'b0;
   logic [1:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         irq;

   int total = 0;
   int bad   = 0;
   int expc [N];
   bit m_warn = 0;
   bit m_frz  = 0;

   always #10 clk = ~clk;

   mac_stat_bank #(.NUM_CNT(N), .CNT_W(W), .THRESH(THR), .RD_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .ctl_wr_i(ctl_wr),
      .ctl_data_i(ctl_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .irq_o(irq));

   task automatic chk(input string tag, input int act, input int exp_v);
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   function automatic bit irq_model();
      bit any = 0;
      for (int i = 0; i < N; i++) if (expc[i] == THR) any = 1;
      return m_warn && any;
   endfunction

   // one clock with the given stimulus; starts and ends at a falling edge
   task automatic step(input logic [N-1:0] ev, input bit cw, input logic [3:0] cd,
                       input bit re, input int ra, input string tag);
      int rdv;
      bit clr, stb, bmp;
      evt = ev; ctl_wr = cw; ctl_data = cd; rd_en = re; rd_addr = 2'(ra);
      @(posedge clk);
      rdv = expc[ra];
      clr = cw && cd[2];
      stb = cw && cd[3];
      for (int i = 0; i < N; i++) begin
         bmp = (ev[i] && !m_frz) || stb;
         if (clr) expc[i] = 0;
         else if (re && ra == i) expc[i] = bmp ? 1 : 0;
         else if (bmp && expc[i] < THR) expc[i]++;
      end
      if (cw) begin m_warn = cd[0]; m_frz = cd[1]; end
      @(negedge clk);
      evt = '0; ctl_wr = 1'b0; ctl_data = '0; rd_en = 1'b0;
      if (re) chk({tag, " read"}, int'(rd_data), rdv);
      chk({"R9 irq during ", tag}, int'(irq), int'(irq_model()));
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < N; i++) step('0, 0, 4'h0, 1, i, tag);
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) expc[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", int'(irq), 0);
      read_all("R1");

      // R2: sweep all event masks, several passes, then read back
      for (int k = 0; k < 48; k++) step(4'(k), 0, 4'h0, 0, 0, "R2");
      read_all("R2");
      for (int k = 0; k < 16; k++) step(4'(k * 7), 0, 4'h0, (k % 3) == 0, k % N, "R3");
      read_all("R3");

      // R4: read and event on the same counter
      for (int i = 0; i < N; i++) begin
         for (int k = 0; k < i + 3; k++) step(4'b1 << i, 0, 4'h0, 0, 0, "R4");
         step(4'b1 << i, 0, 4'h0, 1, i, "R4");
         step('0, 0, 4'h0, 1, i, "R4 ends at one");
      end

      // R5: freeze takes effect the cycle after its write; reads still clear
      step(4'hF, 1, 4'b0010, 0, 0, "R5");
      for (int k = 0; k < 10; k++) step(4'(k), 0, 4'h0, 0, 0, "R5");
      step(4'b0010, 0, 4'h0, 1, 1, "R5 frozen read");
      read_all("R5");

      // R7: strobe while frozen, strobe with event
      step(4'hF, 1, 4'b1010, 0, 0, "R7");
      read_all("R7");
      step(4'h0, 1, 4'b0000, 0, 0, "R10");
      step(4'b0101, 1, 4'b1000, 0, 0, "R7");
      read_all("R7 strobe plus event");

      // R6: clear wins over strobe, events and reads; not retained
      for (int k = 0; k < 9; k++) step(4'hF, 0, 4'h0, 0, 0, "R6");
      step(4'hF, 1, 4'b1100, 1, 3, "R6");
      step(4'hF, 0, 4'h0, 0, 0, "R6 not retained");
      read_all("R6");

      // R8/R9: saturation and interrupt
      step('0, 1, 4'b0001, 0, 0, "R10");
      for (int k = 0; k < THR + 20; k++) step(4'b0100, 0, 4'h0, 0, 0, "R8");
      chk("R8 irq at threshold", int'(irq), 1);
      step(4'b0100, 0, 4'h0, 1, 2, "R8 saturated");
      chk("R9 irq drops after read", int'(irq), 0);
      step('0, 1, 4'b0000, 0, 0, "R10");
      for (int k = 0; k < THR + 5; k++) step(4'b0001, 0, 4'h0, 0, 0, "R9");
      chk("R9 irq masked", int'(irq), 0);
      step('0, 1, 4'b0001, 0, 0, "R9 enable");
      chk("R9 irq enabled", int'(irq), 1);
      step('0, 1, 4'b0101, 0, 0, "R9 clear");
      chk("R9 irq after clear", int'(irq), 0);
      read_all("R8");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule